// File: doc/BRIEF.md
# Multi-Mode I/O Pin Output Controller

This block drives a small group of I/O pins, each through a high-side and a low-side drive output. A two-bit mode field per pin selects one of four behaviours: a plain input with both drivers off, a static level taken from the pin's own output register, an 8-bit pulse-width waveform from a single generator that all such pins share, or cyclic sensing. In cyclic sensing the high-side driver is switched on and off periodically as a supply for an external wake-up switch, and the switch state is captured near the end of each supply phase.

All settings arrive through one register-write port. Pin configuration, the shared duty value and the cyclic-sense half period are separate addresses. A base-clock strobe paces both the PWM counter and the cyclic divider. A low-power reset input discards the duty value, so a pin in PWM mode stays low until software writes a new duty. The raw pin inputs are passed back unchanged in every mode.

Top module: `iopin_ctrl`

## Requirements
- R1: Mode encoding per pin is bits [1:0] of the pin configuration byte: 0 input, 1 level, 2 PWM, 3 cyclic sense. In input mode both `hs_drv` and `ls_drv` of the pin are 0, whatever the other fields hold.
- R2: Configuration byte bit 2 is the high-side enable, bit 3 the low-side enable, bit 4 the output value. In level mode `hs_drv` = enable_hs AND value and `ls_drv` = enable_ls AND NOT value. The same rule applies in PWM mode, with the waveform taking the place of the value.
- R3: The PWM counter advances by one on each cycle with `tick` high and wraps after 256 counts. The waveform is high while the counter is below the duty, so a duty of D gives D high ticks out of 256, and a duty of 0 gives constant low. With `tick` low the waveform holds.
- R4: Every pin in PWM mode with its high-side enable set shows the same waveform in the same cycle.
- R5: In cyclic sense with high-side enable 1 and low-side enable 0, `ls_drv` is 0 and `hs_drv` alternates between runs of H+1 high ticks and H+1 low ticks, where H is the half-period register. It changes only on ticks.
- R6: Cyclic sense with any other pair of enables drives both outputs to 0 and raises `cfg_err` for that pin. `cfg_err` is 0 in all other cases.
- R7: On the last tick of each supply phase, a valid cyclic-sense pin copies `pin_in` into its `cs_status` bit. At no other time does `cs_status` change.
- R8: A `lp_rst` pulse clears the duty to 0x00 and restarts the PWM counter. It has priority over a duty write in the same cycle, and it leaves the pin configuration registers unchanged.
- R9: `pin_rd` equals `pin_in` in every mode.
- R10: After `rst_n`, every configuration register holds 0, so all drivers, `cfg_err` and `cs_status` are 0. The half period resets to 3.
- R11: Write addresses: 0 to NPINS-1 select a pin configuration byte, NPINS selects the duty, NPINS+1 selects the half period. A write takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lp_rst | input | 1 | Low-power reset: clears duty, restarts PWM counter |
| tick | input | 1 | Base-clock strobe for PWM and cyclic divider |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register address |
| wr_data | input | DATA_W (8) | Register write data |
| pin_in | input | NPINS (4) | Pin input levels |
| pin_rd | output | NPINS (4) | Pin input readback |
| hs_drv | output | NPINS (4) | High-side drive per pin |
| ls_drv | output | NPINS (4) | Low-side drive per pin |
| cfg_err | output | NPINS (4) | Invalid cyclic-sense enable setting per pin |
| cs_status | output | NPINS (4) | Last sensed switch state per pin |

## Verification
The checker runs on every cycle and tests the following:
- the waveforms of all PWM pins agree;
- the waveform is low at zero duty;
- a low-power reset leaves the duty at zero;
- the cyclic phase holds without a tick;
- `cs_status` moves only on a sample strobe;
- an erroring pin drives nothing;
- the readback mirrors the input.

Other properties need a window of cycles, and only the bench scenarios show them. These are the exact high-tick count for every duty value 0 to 255, the H+1 run lengths for several half periods, the captured switch value, and the decode of every enable and value combination in each mode.

// File: rtl/iopin_pkg.sv
package iopin_pkg;

   typedef enum logic [1:0] {
      MODE_INPUT  = 2'd0,
      MODE_LEVEL  = 2'd1,
      MODE_PWM    = 2'd2,
      MODE_CSENSE = 2'd3
   } pin_mode_e;

   // Packed LSB-first: mode [1:0], hs_en [2], ls_en [3], value [4]
   typedef struct packed {
      logic      value;
      logic      ls_en;
      logic      hs_en;
      pin_mode_e mode;
   } pin_cfg_t;

   localparam int CFG_W = $bits(pin_cfg_t);

endpackage

// File: rtl/iopin_pwm.sv
module iopin_pwm #(
   parameter int PWM_W = 8,
   parameter bit RESTART_ON_LP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lp_rst,
   input  logic             tick,
   input  logic             duty_we,
   input  logic [PWM_W-1:0] duty_wd,
   output logic [PWM_W-1:0] duty_q,
   output logic             pwm_wave
);

   if (PWM_W < 2 || PWM_W > 16) begin : g_bad_w
      $error("iopin_pwm: PWM_W out of range");
   end

   logic [PWM_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       duty_q <= '0;
      else if (lp_rst)  duty_q <= '0;
      else if (duty_we) duty_q <= duty_wd;
   end

   if (RESTART_ON_LP) begin : g_cnt_restart
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt_q <= '0;
         else if (lp_rst) cnt_q <= '0;
         else if (tick)   cnt_q <= cnt_q + PWM_W'(1);
      end
   end else begin : g_cnt_free
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt_q <= '0;
         else if (tick) cnt_q <= cnt_q + PWM_W'(1);
      end
   end

   assign pwm_wave = (cnt_q < duty_q);

endmodule

// File: rtl/iopin_cyclic.sv
module iopin_cyclic #(
   parameter int DIV_W   = 8,
   parameter int HALF_RST = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             half_we,
   input  logic [DIV_W-1:0] half_wd,
   output logic             cs_phase,
   output logic             cs_smp
);

   if (DIV_W < 1 || HALF_RST >= (1 << DIV_W)) begin : g_bad_div
      $error("iopin_cyclic: bad DIV_W or HALF_RST");
   end

   logic [DIV_W-1:0] half_q;
   logic [DIV_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q >= half_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       half_q <= DIV_W'(HALF_RST);
      else if (half_we) half_q <= half_wd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         cs_phase <= 1'b0;
      end else if (tick) begin
         if (at_end) begin
            cnt_q    <= '0;
            cs_phase <= ~cs_phase;
         end else begin
            cnt_q <= cnt_q + DIV_W'(1);
         end
      end
   end

   // Last tick of a supply phase
   assign cs_smp = tick & cs_phase & at_end;

endmodule

// File: rtl/iopin_pin.sv
module iopin_pin
   import iopin_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cfg_we,
   input  pin_cfg_t cfg_wd,
   input  logic     pwm_wave,
   input  logic     cs_phase,
   input  logic     cs_smp,
   input  logic     pin_in,
   output logic     hs_drv,
   output logic     ls_drv,
   output logic     cfg_err,
   output logic     cs_status,
   output logic     pwm_sel
);

   pin_cfg_t cfg_q;
   logic     cs_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_we) cfg_q <= cfg_wd;
   end

   assign cs_ok   = cfg_q.hs_en & ~cfg_q.ls_en;
   assign cfg_err = (cfg_q.mode == MODE_CSENSE) & ~cs_ok;
   assign pwm_sel = (cfg_q.mode == MODE_PWM) & cfg_q.hs_en;

   always_comb begin
      hs_drv = 1'b0;
      ls_drv = 1'b0;
      unique case (cfg_q.mode)
         MODE_INPUT: begin
            hs_drv = 1'b0;
            ls_drv = 1'b0;
         end
         MODE_LEVEL: begin
            hs_drv = cfg_q.hs_en &  cfg_q.value;
            ls_drv = cfg_q.ls_en & ~cfg_q.value;
         end
         MODE_PWM: begin
            hs_drv = cfg_q.hs_en &  pwm_wave;
            ls_drv = cfg_q.ls_en & ~pwm_wave;
         end
         MODE_CSENSE: begin
            hs_drv = cs_ok & cs_phase;
            ls_drv = 1'b0;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cs_status <= 1'b0;
      else if (cs_smp && cfg_q.mode == MODE_CSENSE && cs_ok)
         cs_status <= pin_in;
   end

endmodule

// File: rtl/iopin_ctrl.sv
module iopin_ctrl
   import iopin_pkg::*;
#(
   parameter int NPINS    = 4,
   parameter int DATA_W   = 8,
   parameter int PWM_W    = 8,
   parameter int DIV_W    = 8,
   parameter int HALF_RST = 3,
   parameter bit RESTART_ON_LP = 1'b1,
   localparam int ADDR_W  = $clog2(NPINS + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp_rst,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_rd,
   output logic [NPINS-1:0]  hs_drv,
   output logic [NPINS-1:0]  ls_drv,
   output logic [NPINS-1:0]  cfg_err,
   output logic [NPINS-1:0]  cs_status
);

   if (NPINS < 1 || DATA_W < CFG_W || DATA_W < PWM_W || DATA_W < DIV_W) begin : g_bad_cfg
      $error("iopin_ctrl: inconsistent widths");
   end

   localparam logic [ADDR_W-1:0] ADDR_DUTY = ADDR_W'(NPINS);
   localparam logic [ADDR_W-1:0] ADDR_HALF = ADDR_W'(NPINS + 1);

   logic [PWM_W-1:0] duty_q;
   logic             pwm_wave;
   logic             cs_phase;
   logic             cs_smp;
   logic [NPINS-1:0] pwm_sel;

   iopin_pwm #(
      .PWM_W         (PWM_W),
      .RESTART_ON_LP (RESTART_ON_LP)
   ) u_pwm (
      .clk      (clk),
      .rst_n    (rst_n),
      .lp_rst   (lp_rst),
      .tick     (tick),
      .duty_we  (wr_en && wr_addr == ADDR_DUTY),
      .duty_wd  (wr_data[PWM_W-1:0]),
      .duty_q   (duty_q),
      .pwm_wave (pwm_wave)
   );

   iopin_cyclic #(
      .DIV_W    (DIV_W),
      .HALF_RST (HALF_RST)
   ) u_cyc (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .half_we  (wr_en && wr_addr == ADDR_HALF),
      .half_wd  (wr_data[DIV_W-1:0]),
      .cs_phase (cs_phase),
      .cs_smp   (cs_smp)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      iopin_pin u_pin (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_we    (wr_en && wr_addr == ADDR_W'(i)),
         .cfg_wd    (pin_cfg_t'(wr_data[CFG_W-1:0])),
         .pwm_wave  (pwm_wave),
         .cs_phase  (cs_phase),
         .cs_smp    (cs_smp),
         .pin_in    (pin_in[i]),
         .hs_drv    (hs_drv[i]),
         .ls_drv    (ls_drv[i]),
         .cfg_err   (cfg_err[i]),
         .cs_status (cs_status[i]),
         .pwm_sel   (pwm_sel[i])
      );
   end

   assign pin_rd = pin_in;

endmodule

// File: rtl/iopin_ctrl_chk.sv
module iopin_ctrl_chk #(
   parameter int NPINS = 4,
   parameter int PWM_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lp_rst,
   input logic             tick,
   input logic [NPINS-1:0] pin_in,
   input logic [NPINS-1:0] pin_rd,
   input logic [NPINS-1:0] hs_drv,
   input logic [NPINS-1:0] ls_drv,
   input logic [NPINS-1:0] cfg_err,
   input logic [NPINS-1:0] cs_status,
   input logic [PWM_W-1:0] duty_q,
   input logic             pwm_wave,
   input logic [NPINS-1:0] pwm_sel,
   input logic             cs_phase,
   input logic             cs_smp
);

   a_r3_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_q == '0) |-> !pwm_wave);

   a_r8_lp_clears_duty: assert property (@(posedge clk) disable iff (!rst_n)
      lp_rst |=> (duty_q == '0) && !pwm_wave);

   a_r5_phase_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cs_phase));

   a_r7_status_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_smp |=> $stable(cs_status));

   a_r9_readback: assert property (@(posedge clk) disable iff (!rst_n)
      pin_rd == pin_in);

   for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
      a_r4_pwm_shared: assert property (@(posedge clk) disable iff (!rst_n)
         pwm_sel[i] |-> (hs_drv[i] == pwm_wave));

      a_r6_err_drives_off: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_err[i] |-> (!hs_drv[i] && !ls_drv[i]));
   end

endmodule

bind iopin_ctrl iopin_ctrl_chk #(
   .NPINS (NPINS),
   .PWM_W (PWM_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lp_rst    (lp_rst),
   .tick      (tick),
   .pin_in    (pin_in),
   .pin_rd    (pin_rd),
   .hs_drv    (hs_drv),
   .ls_drv    (ls_drv),
   .cfg_err   (cfg_err),
   .cs_status (cs_status),
   .duty_q    (duty_q),
   .pwm_wave  (pwm_wave),
   .pwm_sel   (pwm_sel),
   .cs_phase  (cs_phase),
   .cs_smp    (cs_smp)
);

// File: tb/iopin_ctrl_bench.sv
module iopin_ctrl_bench;

   localparam int CLK_P = 10;
   localparam int NP    = 4;
   localparam int AW    = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lp_rst = 1'b0;
   logic          tick = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_rd, hs_drv, ls_drv, cfg_err, cs_status;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   iopin_ctrl u_iopin_ctrl (
      .clk(clk), .rst_n(rst_n), .lp_rst(lp_rst), .tick(tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pin_in(pin_in), .pin_rd(pin_rd), .hs_drv(hs_drv), .ls_drv(ls_drv),
      .cfg_err(cfg_err), .cs_status(cs_status)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic int cfg(input int mode, input int hs, input int ls, input int val);
      return (val << 4) | (ls << 3) | (hs << 2) | mode;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int cnt, cnt2, mism;
      logic prev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 hs", hs_drv, 0);
      check("R10 ls", ls_drv, 0);
      check("R10 err", cfg_err, 0);
      check("R10 status", cs_status, 0);

      // R9 readback across all input patterns
      for (int v = 0; v < 16; v++) begin
         pin_in = NP'(v); #1;
         check("R9 readback", pin_rd, v);
      end
      pin_in = '0;

      // R1 input mode and R2 level mode, all enable/value combos (R11 pin address 0)
      for (int c = 0; c < 8; c++) begin
         wr(0, cfg(0, c & 1, (c >> 1) & 1, (c >> 2) & 1));
         check("R1 input hs", hs_drv[0], 0);
         check("R1 input ls", ls_drv[0], 0);
         wr(0, cfg(1, c & 1, (c >> 1) & 1, (c >> 2) & 1));
         check("R2 level hs", hs_drv[0], (c & 1) & ((c >> 2) & 1));
         check("R2 level ls", ls_drv[0], ((c >> 1) & 1) & (((c >> 2) & 1) ^ 1));
      end

      // R3/R4 exhaustive duty sweep; pin1 and pin2 in PWM
      wr(1, cfg(2, 1, 1, 0));
      wr(2, cfg(2, 1, 0, 0));
      tick = 1'b1;
      for (int d = 0; d < 256; d++) begin
         wr(NP, d);   // R11 duty address
         cnt = 0; cnt2 = 0; mism = 0;
         for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            if (hs_drv[1]) cnt++;
            if (ls_drv[1]) cnt2++;
            if (hs_drv[2] != hs_drv[1]) mism++;
         end
         check("R3 duty high ticks", cnt, d);
         check("R2 pwm low side", cnt2, 256 - d);
         check("R4 shared waveform", mism, 0);
      end

      // R3 hold without tick
      wr(NP, 100);
      tick = 1'b0;
      @(negedge clk);
      prev = hs_drv[1]; mism = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (hs_drv[1] != prev) mism++;
      end
      check("R3 hold without tick", mism, 0);
      tick = 1'b1;

      // R8 low-power reset clears duty, keeps pin config
      wr(0, cfg(1, 1, 0, 1));
      wr(NP, 200);
      @(negedge clk); lp_rst = 1'b1;
      @(negedge clk); lp_rst = 1'b0;
      cnt = 0;
      for (int k = 0; k < 256; k++) begin
         @(negedge clk);
         if (hs_drv[1]) cnt++;
      end
      check("R8 duty cleared", cnt, 0);
      check("R8 level pin kept", hs_drv[0], 1);
      check("R8 pwm pin cfg kept", ls_drv[1], 1);
      // R8 priority over simultaneous duty write
      @(negedge clk);
      lp_rst = 1'b1; wr_en = 1'b1; wr_addr = AW'(NP); wr_data = 8'd255;
      @(negedge clk);
      lp_rst = 1'b0; wr_en = 1'b0;
      cnt = 0;
      for (int k = 0; k < 256; k++) begin
         @(negedge clk);
         if (hs_drv[1]) cnt++;
      end
      check("R8 priority over write", cnt, 0);

      // R6 invalid cyclic-sense enables
      for (int c = 0; c < 4; c++) begin
         wr(3, cfg(3, c & 1, (c >> 1) & 1, 1));
         cnt = 0;
         for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (hs_drv[3] || ls_drv[3]) cnt++;
         end
         check("R6 err flag", cfg_err[3], (c == 1) ? 0 : 1);
         if (c != 1) check("R6 drivers off", cnt, 0);
      end

      // R5 cyclic period for several half values (R11 half address)
      wr(3, cfg(3, 1, 0, 0));
      for (int h = 0; h < 6; h++) begin
         wr(NP + 1, h);
         repeat (4 * (h + 1) + 2) @(negedge clk);
         cnt = 0; cnt2 = 0;
         for (int k = 0; k < 2 * (h + 1); k++) begin
            @(negedge clk);
            if (hs_drv[3]) cnt++;
            if (ls_drv[3]) cnt2++;
         end
         check("R5 supply ticks", cnt, h + 1);
         check("R5 low side off", cnt2, 0);
      end

      // R7 sensing into status
      wr(NP + 1, 3);
      pin_in[3] = 1'b1;
      repeat (20) @(negedge clk);
      check("R7 status high", cs_status[3], 1);
      pin_in[3] = 1'b0;
      repeat (20) @(negedge clk);
      check("R7 status low", cs_status[3], 0);
      pin_in[3] = 1'b1;
      repeat (20) @(negedge clk);
      wr(3, cfg(1, 0, 0, 0));
      pin_in[3] = 1'b0;
      repeat (20) @(negedge clk);
      check("R7 status held outside mode", cs_status[3], 1);

      finish_run();
   end

endmodule